// File: doc/BRIEF.md
# Range-Gated Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands. The datapath is cut into a lower byte (bits 7:0) and an upper byte (bits 15:8). A detector looks at the upper byte of the first operand and at the upper byte of the effective second operand. The effective second operand is the operand itself for addition, or its bitwise inverse for subtraction. When each of these bytes is pure sign extension (0x00 or 0xFF), the upper byte carries no information of its own. In that case the upper adder's inputs are forced to zero so they stop toggling. The upper result byte and the carry-out are then rebuilt from the lower-byte carry and the two byte patterns.

The detector outputs are captured in a register before they reach the gating. The operands and the lower-byte sum are captured in the same register stage. Result and controls therefore stay aligned: operands presented before a rising edge give their result after that edge, and it holds until the next one. Subtraction is formed as A + ~B + 1, so the carry-out reads as "no borrow".

Top module: `range_gated_addsub`

## Requirements
- R1: While rst_n is low the outputs read sumOut = 0 and carryOut = 0. The first capture after reset is released sets them.
- R2: With subSel = 0, after a rising edge {carryOut, sumOut} equals the 17-bit unsigned sum of the opA and opB sampled at that edge.
- R3: With subSel = 1, after a rising edge sumOut equals opA − opB modulo 2^16, and carryOut is 1 exactly when opA ≥ opB as unsigned numbers.
- R4: The upper part is closed exactly when opA[15:8] is 0x00 or 0xFF and the effective second upper byte is also 0x00 or 0xFF. The effective second upper byte is opB[15:8] for addition and ~opB[15:8] for subtraction.
- R5: While closed, both upper adder inputs are zero. While open, they equal the captured upper bytes of opA and of the effective second operand.
- R6: While closed, the rebuilt upper byte and carry-out equal those of a full 16-bit addition. This holds for all four 0x00/0xFF pairings, with the lower-byte carry at either value.
- R7: Every result appears after exactly one rising edge, even when the operands change every cycle and alternate between the closed and open cases.
- R8: In subtraction, detection uses the inverted second operand, so opB[15:8] = 0x00 with subSel = 1 counts as an all-ones byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| subSel | input | 1 | 1 = subtract opB from opA, 0 = add |
| sumOut | output | 16 | Registered-stage result, modulo 2^16 |
| carryOut | output | 1 | Carry out of bit 15 (no-borrow flag when subtracting) |

## Verification
Two things can fall in the same cycle: the upper part is shut off and rebuilt, and the lower-byte carry ripples into the upper byte. When that happens, the rebuild alone must produce the bit-8 increment or wrap and the final carry-out. The bench provokes this with every 0x00/0xFF upper pairing, in both add and subtract. It sweeps all 256 lower bytes of the first operand against a spread of lower bytes of the second, so the lower carry takes both values under each pairing. Each result is judged against the arithmetic sum or difference, computed in the bench one cycle after the operands were driven. The bench also streams closed and open operands alternately, to confirm that the controls and data stay aligned.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  // Strobes sent from the control path to the datapath.
  // All of them are zero while the upper part is open.
  typedef struct packed {
    logic close;   // upper part shut off, gate its inputs
    logic carry;   // rebuilt carry-out
    logic fill;    // rebuilt value of upper bits above the lowest one
    logic lowBit;  // rebuilt value of the lowest upper bit
  } ctlStrobes_t;

endpackage

// File: rtl/rsa_ripple.sv
module rsa_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  // One full-adder cell per bit, carry rippling upward.
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic prop;
    logic gen;
    assign prop       = a[i] ^ b[i];
    assign gen        = a[i] & b[i];
    assign sum[i]     = prop ^ chain[i];
    assign chain[i+1] = gen | (prop & chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
#(
  parameter int HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIGH_W-1:0] hiA,
  input  logic [HIGH_W-1:0] hiB,
  input  logic              subSel,
  input  logic              lowCarryQ,
  output ctlStrobes_t       ctl
);

  logic [HIGH_W-1:0] hiBEff;
  logic aOnes;
  logic aZeros;
  logic bOnes;
  logic bZeros;
  logic closeD;

  // Detection on the raw, possibly glitching operand bytes.
  assign hiBEff = subSel ? ~hiB : hiB;
  assign aOnes  = &hiA;
  assign aZeros = ~(|hiA);
  assign bOnes  = &hiBEff;
  assign bZeros = ~(|hiBEff);
  assign closeD = (aOnes | aZeros) & (bOnes | bZeros);

  // Capture stage: only settled values reach the gating.
  logic closeQ;
  logic aOnesQ;
  logic bOnesQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      closeQ <= 1'b0;
      aOnesQ <= 1'b0;
      bOnesQ <= 1'b0;
    end else begin
      closeQ <= closeD;
      aOnesQ <= aOnes;
      bOnesQ <= bOnes;
    end
  end

  // Rebuild terms. When closed, an upper byte not all ones is all zeros.
  logic bothOnes;
  logic oneOnes;

  assign bothOnes = aOnesQ & bOnesQ;
  assign oneOnes  = aOnesQ ^ bOnesQ;

  always_comb begin
    ctl        = '0;
    ctl.close  = closeQ;
    ctl.carry  = closeQ & (bothOnes | (oneOnes & lowCarryQ));
    ctl.fill   = closeQ & (bothOnes | (oneOnes & ~lowCarryQ));
    ctl.lowBit = closeQ & (lowCarryQ ^ oneOnes);
  end

endmodule

// File: rtl/rsa_datapath.sv
module rsa_datapath
  import rsa_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        opA,
  input  logic [WIDTH-1:0]        opB,
  input  logic                    subSel,
  input  ctlStrobes_t             ctl,
  output logic                    lowCarryQ,
  output logic [WIDTH-LOW_W-1:0]  gateHiA,
  output logic [WIDTH-LOW_W-1:0]  gateHiB,
  output logic [WIDTH-1:0]        sumOut,
  output logic                    carryOut
);

  localparam int HIGH_W = WIDTH - LOW_W;

  // Effective second operand: inverted for subtraction, carry-in 1.
  logic [WIDTH-1:0] bEff;
  assign bEff = subSel ? ~opB : opB;

  // Lower part always runs.
  logic [LOW_W-1:0] lowSumD;
  logic             lowCarryD;

  rsa_ripple #(.W(LOW_W)) u_low (
    .a    (opA[LOW_W-1:0]),
    .b    (bEff[LOW_W-1:0]),
    .cin  (subSel),
    .sum  (lowSumD),
    .cout (lowCarryD)
  );

  // Stage register, aligned with the captured controls.
  logic [HIGH_W-1:0] hiAQ;
  logic [HIGH_W-1:0] hiBQ;
  logic [LOW_W-1:0]  lowSumQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiAQ      <= '0;
      hiBQ      <= '0;
      lowSumQ   <= '0;
      lowCarryQ <= 1'b0;
    end else begin
      hiAQ      <= opA[WIDTH-1:LOW_W];
      hiBQ      <= bEff[WIDTH-1:LOW_W];
      lowSumQ   <= lowSumD;
      lowCarryQ <= lowCarryD;
    end
  end

  // AND-style gating of the upper adder inputs.
  logic [HIGH_W-1:0] gateMask;
  logic              gateCin;

  assign gateMask = {HIGH_W{~ctl.close}};
  assign gateHiA  = hiAQ & gateMask;
  assign gateHiB  = hiBQ & gateMask;
  assign gateCin  = lowCarryQ & ~ctl.close;

  logic [HIGH_W-1:0] hiSum;
  logic              hiCout;

  rsa_ripple #(.W(HIGH_W)) u_high (
    .a    (gateHiA),
    .b    (gateHiB),
    .cin  (gateCin),
    .sum  (hiSum),
    .cout (hiCout)
  );

  // Rebuilt upper byte when closed.
  logic [HIGH_W-1:0] hiRebuilt;
  assign hiRebuilt = {{(HIGH_W-1){ctl.fill}}, ctl.lowBit};

  always_comb begin
    if (ctl.close) begin
      sumOut   = {hiRebuilt, lowSumQ};
      carryOut = ctl.carry;
    end else begin
      sumOut   = {hiSum, lowSumQ};
      carryOut = hiCout;
    end
  end

endmodule

// File: rtl/range_gated_addsub.sv
module range_gated_addsub
  import rsa_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subSel,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int HIGH_W = WIDTH - LOW_W;

  ctlStrobes_t       ctl;
  logic              lowCarryQ;
  logic [HIGH_W-1:0] gateHiA;
  logic [HIGH_W-1:0] gateHiB;
  logic              closeNow;

  assign closeNow = ctl.close;

  rsa_ctrl #(.HIGH_W(HIGH_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hiA       (opA[WIDTH-1:LOW_W]),
    .hiB       (opB[WIDTH-1:LOW_W]),
    .subSel    (subSel),
    .lowCarryQ (lowCarryQ),
    .ctl       (ctl)
  );

  rsa_datapath #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .opA       (opA),
    .opB       (opB),
    .subSel    (subSel),
    .ctl       (ctl),
    .lowCarryQ (lowCarryQ),
    .gateHiA   (gateHiA),
    .gateHiB   (gateHiB),
    .sumOut    (sumOut),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [WIDTH-1:0]       opA,
  input logic [WIDTH-1:0]       opB,
  input logic                   subSel,
  input logic [WIDTH-1:0]       sumOut,
  input logic                   carryOut,
  input logic                   closeQ,
  input logic [WIDTH-LOW_W-1:0] gateHiA,
  input logic [WIDTH-LOW_W-1:0] gateHiB
);

  localparam int HIGH_W = WIDTH - LOW_W;

  // Set once a capture has happened with reset released.
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic [HIGH_W-1:0] hiA;
  logic [HIGH_W-1:0] hiBEff;
  logic              detNow;
  logic [WIDTH:0]    refFull;

  assign hiA     = opA[WIDTH-1:LOW_W];
  assign hiBEff  = subSel ? ~opB[WIDTH-1:LOW_W] : opB[WIDTH-1:LOW_W];
  assign detNow  = ((hiA == '0) || (hiA == '1)) && ((hiBEff == '0) || (hiBEff == '1));
  assign refFull = subSel ? ({1'b0, opA} - {1'b0, opB} + {1'b1, {WIDTH{1'b0}}})
                          : ({1'b0, opA} + {1'b0, opB});

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (sumOut == '0 && carryOut == 1'b0));

  // R2: addition result one edge later
  p_add_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(subSel)) |-> ({carryOut, sumOut} == $past(refFull)));

  // R3: subtraction result and no-borrow flag
  p_sub_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(subSel)) |-> ({carryOut, sumOut} == $past(refFull)));

  // R4 and R8: close follows the detection on the effective operand
  p_close_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (closeQ == $past(detNow)));

  // R5: gated inputs are zero while closed
  p_gate_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    closeQ |-> (gateHiA == '0 && gateHiB == '0));

  // R5: gated inputs pass while open
  p_gate_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !closeQ) |-> (gateHiA == $past(hiA) && gateHiB == $past(hiBEff)));

  // R6: rebuilt result exact while closed
  p_rebuild_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && closeQ) |-> ({carryOut, sumOut} == $past(refFull)));

endmodule

bind range_gated_addsub rsa_checker #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opA      (opA),
  .opB      (opB),
  .subSel   (subSel),
  .sumOut   (sumOut),
  .carryOut (carryOut),
  .closeQ   (closeNow),
  .gateHiA  (gateHiA),
  .gateHiB  (gateHiB)
);

// File: tb/range_gated_addsub_tb.sv
module range_gated_addsub_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        subSel = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic        pendValid = 1'b0;
  logic [16:0] pendExp = '0;
  string       pendTag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  range_gated_addsub u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .opA      (opA),
    .opB      (opB),
    .subSel   (subSel),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // Expected {carry, result}: R2 plain sum, R3 difference with no-borrow flag.
  function automatic logic [16:0] expect_of(logic [15:0] a, logic [15:0] b, logic s);
    logic [16:0] r;
    if (s) begin
      r[15:0] = a - b;
      r[16]   = (a >= b);
    end else begin
      r = {1'b0, a} + {1'b0, b};
    end
    return r;
  endfunction

  task automatic check(logic [16:0] act, logic [16:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual carry=%0b sum=%h expected carry=%0b sum=%h",
               tag, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  // Called at a falling edge: judges the previous operands, drives new ones.
  task automatic step(logic [15:0] a, logic [15:0] b, logic s, string tag);
    if (pendValid) check({carryOut, sumOut}, pendExp, pendTag);
    opA = a;
    opB = b;
    subSel = s;
    pendExp = expect_of(a, b, s);
    pendTag = tag;
    pendValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs at zero even with live operands.
    opA = 16'hFFFF;
    opB = 16'h0001;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({carryOut, sumOut}, 17'h0, "R1 reset state");
    end
    rst_n = 1'b1;

    // R6 with R8: every 0x00/0xFF pairing, lower carry both ways.
    for (int s = 0; s < 2; s++) begin
      for (int u = 0; u < 4; u++) begin
        for (int al = 0; al < 256; al++) begin
          for (int bl = 0; bl < 256; bl += 15) begin
            logic [7:0] ah;
            logic [7:0] bh;
            ah = u[0] ? 8'hFF : 8'h00;
            bh = u[1] ? 8'hFF : 8'h00;
            if (s == 1) bh = ~bh;
            step({ah, al[7:0]}, {bh, bl[7:0]}, s[0],
                 (s == 1) ? "R6 R8 R3 closed subtract" : "R6 R2 closed add");
          end
        end
      end
    end

    // R4 and R5: upper byte of A swept across the open/closed border.
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int ah = 0; ah < 256; ah++) begin
          logic [7:0] bh;
          case (k)
            0: bh = 8'h00;
            1: bh = 8'hFF;
            2: bh = 8'h01;
            default: bh = 8'h80;
          endcase
          step({ah[7:0], 8'hF0}, {bh, 8'h1F}, s[0], "R4 R5 border carry");
          step({ah[7:0], 8'h00}, {bh, 8'h00}, s[0], "R4 R5 border zero");
        end
      end
    end

    // R2 and R3: random operands.
    for (int i = 0; i < 3000; i++) step($urandom, $urandom, 1'b0, "R2 random add");
    for (int i = 0; i < 3000; i++) step($urandom, $urandom, 1'b1, "R3 random subtract");

    // R3 boundary: equal operands and one-apart operands.
    step(16'h1234, 16'h1234, 1'b1, "R3 equal operands");
    step(16'h1233, 16'h1234, 1'b1, "R3 borrow by one");
    step(16'h0000, 16'hFFFF, 1'b1, "R3 zero minus max");
    step(16'hFFFF, 16'h0001, 1'b0, "R2 full wrap");

    // R7: closed and open operands alternate every cycle.
    for (int i = 0; i < 600; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (i % 2 == 0) step({{8{r[7]}}, r[7:0]}, {{8{r[15]}}, r[15:8]}, r[3], "R7 stream closed");
      else            step(r, {r[7:0], r[15:8]} ^ 16'h5A3C, r[4], "R7 stream open");
    end
    step(16'h0000, 16'h0000, 1'b0, "R7 drain");
    step(16'h0000, 16'h0000, 1'b0, "R7 drain");

    finish_run();
  end

endmodule